// File: doc/BRIEF.md
# UART Interrupt Identification Encoder

This block decides which of the five interrupt sources of a 16550-style serial port is reported to the host. It then presents that choice as an identification byte and as a level interrupt line. Its inputs are the line status error flags, the data-ready flag, a character-timeout flag, the receive FIFO fill count and trigger threshold, the FIFO enable bit and the modem status change flags. It holds the four-bit interrupt enable register and the hidden "transmitter empty pending" flag. The register strobes of the host bus set and clear that flag.

The identification byte and the interrupt line are combinational in the current enables, flags and pending bit. A host read of the identification register returns the byte present in the cycle of the read strobe. Any clear that the read causes takes effect from the next clock edge. The FIFO storage, the shifters, the baud timing and the address decoding sit outside the block and reach it only as flags, counts and strobes.

Top module: `uart_irq_ident`

## Requirements
- R1: A write to the enable register stores only write-data bits 3:0 (bit0 receive data, bit1 transmitter empty, bit2 line status, bit3 modem status). The `ier_q` readback shows those bits with bits 7:4 always zero.
- R2: When enable bit2 is set and any of `line_err[3:0]` is set, the low nibble of the identification byte is 0x6. This takes precedence over every other source.
- R3: When `rx_timeout` is set and enable bit0 is set, with no line status source active, the low nibble is 0xC. With enable bit0 clear, the timeout is never reported.
- R4: Receive data is reported as 0x4, below line status and timeout. It needs enable bit0 and `data_ready`, and either `fifo_en` low or `rx_count >= rx_trigger`.
- R5: Transmitter empty is reported as 0x2, below receive data, when enable bit1 is set and the pending flag is 1.
- R6: Modem status is reported as 0x0, lowest priority, when enable bit3 is set and any `msr_delta` bit is set. With no active source the low nibble is 0x1. Bits 7:6 equal `fifo_en` repeated twice and bits 5:4 are zero.
- R7: `irq` is high exactly when the low nibble is not 0x1.
- R8: The pending flag clears at the next edge after a read strobe whose cycle reports 0x2. A read in a cycle reporting any other value leaves it unchanged. A holding-register write clears it and overrides any set in the same cycle.
- R9: The pending flag is set at the next edge by `tx_empty_evt`, or by an enable-register write while `thr_empty` is high.
- R10: After reset the enable register is 0, the pending flag is 0, the identification byte is 0x01 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| thr_wr | input | 1 | Holding register write strobe |
| iir_rd | input | 1 | Identification register read strobe |
| thr_empty | input | 1 | Holding register currently empty |
| tx_empty_evt | input | 1 | Transmitter has just drained its holding data |
| line_err | input | 4 | Overrun, parity, framing, break flags |
| data_ready | input | 1 | Received data available |
| rx_timeout | input | 1 | Character timeout pending |
| fifo_en | input | 1 | FIFO mode enabled |
| rx_count | input | CNT_W | Receive FIFO fill count |
| rx_trigger | input | CNT_W | Receive FIFO trigger threshold |
| msr_delta | input | 4 | Modem status change flags |
| ier_q | output | 8 | Enable register readback |
| iir | output | 8 | Interrupt identification byte |
| irq | output | 1 | Level interrupt request |

## Verification
The bench uses the default count width of 5 bits, so counts from 0 to 16 and every threshold of a 16-entry FIFO can be driven. The threshold comparison is exercised just below and exactly at the trigger level, in both FIFO and non-FIFO mode. A behavioural reference model follows the enable register and the pending flag each cycle. This lets coincident strobes, such as a holding-register write in the same cycle as a transmitter-empty event, be compared against the stated precedence.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [3:0] {
    ID_MODEM = 4'h0,
    ID_NONE  = 4'h1,
    ID_TXE   = 4'h2,
    ID_RXD   = 4'h4,
    ID_LINE  = 4'h6,
    ID_TMO   = 4'hC
  } irq_id_e;

  localparam int EN_W = 4;

  // Receive threshold test: without FIFO one byte is enough
  function automatic logic rx_level_met(input logic fifo_on,
                                        input logic [15:0] cnt,
                                        input logic [15:0] trig);
    return !fifo_on || (cnt >= trig);
  endfunction

endpackage

// File: rtl/uart_irq_enable_reg.sv
module uart_irq_enable_reg
  import uart_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [EN_W-1:0]   en_q,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else if (wr) en_q <= wdata[EN_W-1:0];
  end

  assign rdata = {{(DATA_W-EN_W){1'b0}}, en_q};

  AST_EN_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (en_q == $past(wdata[EN_W-1:0]))); // R1
endmodule

// File: rtl/uart_irq_thre_pend.sv
module uart_irq_thre_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic thr_wr,
  input  logic tx_empty_evt,
  input  logic ier_wr,
  input  logic thr_empty,
  input  logic id_txe_read,
  output logic pend_q
);
  logic set_evt, clr_evt;

  assign set_evt = tx_empty_evt || (ier_wr && thr_empty);
  assign clr_evt = id_txe_read;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (thr_wr)  pend_q <= 1'b0;
    else if (set_evt) pend_q <= 1'b1;
    else if (clr_evt) pend_q <= 1'b0;
  end

  AST_PEND_THR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> !pend_q); // R8
  AST_PEND_RD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (id_txe_read && !tx_empty_evt && !ier_wr) |=> !pend_q); // R8
  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_empty_evt || (ier_wr && thr_empty)) && !thr_wr) |=> pend_q); // R9
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic [EN_W-1:0]  en,
  input  logic [3:0]       line_err,
  input  logic             data_ready,
  input  logic             rx_timeout,
  input  logic             fifo_en,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rx_trigger,
  input  logic             txe_pend,
  input  logic [3:0]       msr_delta,
  output irq_id_e          id,
  output logic             active
);
  logic src_line, src_tmo, src_rxd, src_txe, src_modem;
  logic [15:0] cnt_w, trig_w;

  assign cnt_w  = 16'(rx_count);
  assign trig_w = 16'(rx_trigger);

  assign src_line  = en[2] && (|line_err);
  assign src_tmo   = en[0] && rx_timeout;
  assign src_rxd   = en[0] && data_ready && rx_level_met(fifo_en, cnt_w, trig_w);
  assign src_txe   = en[1] && txe_pend;
  assign src_modem = en[3] && (|msr_delta);

  always_comb begin
    if (src_line)       id = ID_LINE;
    else if (src_tmo)   id = ID_TMO;
    else if (src_rxd)   id = ID_RXD;
    else if (src_txe)   id = ID_TXE;
    else if (src_modem) id = ID_MODEM;
    else                id = ID_NONE;
  end

  assign active = src_line | src_tmo | src_rxd | src_txe | src_modem;

  always_comb begin
    AST_LINE_TOP: assert (!(en[2] && (|line_err)) || id == ID_LINE); // R2
    AST_TMO_MASK: assert (en[0] || id != ID_TMO); // R3
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int CNT_W  = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ier_wr,
  input  logic [DATA_W-1:0] ier_wdata,
  input  logic              thr_wr,
  input  logic              iir_rd,
  input  logic              thr_empty,
  input  logic              tx_empty_evt,
  input  logic [3:0]        line_err,
  input  logic              data_ready,
  input  logic              rx_timeout,
  input  logic              fifo_en,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic [CNT_W-1:0]  rx_trigger,
  input  logic [3:0]        msr_delta,
  output logic [DATA_W-1:0] ier_q,
  output logic [DATA_W-1:0] iir,
  output logic              irq
);
  logic [EN_W-1:0] en_bits;
  logic            pend;
  irq_id_e         cur_id;
  logic            any_src;
  logic            id_txe_read;

  uart_irq_enable_reg #(.DATA_W(DATA_W)) u_en (
    .clk(clk), .rst_n(rst_n), .wr(ier_wr), .wdata(ier_wdata),
    .en_q(en_bits), .rdata(ier_q)
  );

  assign id_txe_read = iir_rd && (cur_id == ID_TXE);

  uart_irq_thre_pend u_pend (
    .clk(clk), .rst_n(rst_n), .thr_wr(thr_wr), .tx_empty_evt(tx_empty_evt),
    .ier_wr(ier_wr), .thr_empty(thr_empty), .id_txe_read(id_txe_read),
    .pend_q(pend)
  );

  uart_irq_prio #(.CNT_W(CNT_W)) u_prio (
    .en(en_bits), .line_err(line_err), .data_ready(data_ready),
    .rx_timeout(rx_timeout), .fifo_en(fifo_en), .rx_count(rx_count),
    .rx_trigger(rx_trigger), .txe_pend(pend), .msr_delta(msr_delta),
    .id(cur_id), .active(any_src)
  );

  assign iir = {{2{fifo_en}}, {(DATA_W-6){1'b0}}, cur_id};
  assign irq = any_src;

  AST_IRQ_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (iir[3:0] != 4'h1)); // R7
  AST_FIFO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (iir[7:6] == {2{fifo_en}}) && (iir[5:4] == 2'b00)); // R6
endmodule

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 5;

  logic clk = 0, rst_n = 0;
  logic ier_wr = 0, thr_wr = 0, iir_rd = 0, thr_empty = 0, tx_empty_evt = 0;
  logic [7:0] ier_wdata = 0;
  logic [3:0] line_err = 0, msr_delta = 0;
  logic data_ready = 0, rx_timeout = 0, fifo_en = 0;
  logic [CW-1:0] rx_count = 0, rx_trigger = 0;
  logic [7:0] ier_q, iir;
  logic irq;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_ident #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
    .thr_wr(thr_wr), .iir_rd(iir_rd), .thr_empty(thr_empty),
    .tx_empty_evt(tx_empty_evt), .line_err(line_err), .data_ready(data_ready),
    .rx_timeout(rx_timeout), .fifo_en(fifo_en), .rx_count(rx_count),
    .rx_trigger(rx_trigger), .msr_delta(msr_delta),
    .ier_q(ier_q), .iir(iir), .irq(irq)
  );

  // Behavioural reference model
  int m_en = 0;
  bit m_pend = 0;

  function automatic int model_id();
    if ((m_en & 4) != 0 && line_err != 0) return 6;
    if ((m_en & 1) != 0 && rx_timeout) return 12;
    if ((m_en & 1) != 0 && data_ready && (!fifo_en || int'(rx_count) >= int'(rx_trigger))) return 4;
    if ((m_en & 2) != 0 && m_pend) return 2;
    if ((m_en & 8) != 0 && msr_delta != 0) return 0;
    return 1;
  endfunction

  function automatic int model_iir();
    return (fifo_en ? 8'hC0 : 8'h00) | model_id();
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      int idv;
      idv = model_id();
      if (ier_wr) m_en <= ier_wdata % 16;
      if (thr_wr) m_pend <= 0;
      else if (tx_empty_evt || (ier_wr && thr_empty)) m_pend <= 1;
      else if (iir_rd && idv == 2) m_pend <= 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (int'(iir) != model_iir() || irq != (model_id() != 1) || int'(ier_q) != m_en) begin
        errors++;
        $display("FAIL model compare (R6 R7 identification) got iir=%h irq=%b ier=%h exp iir=%h irq=%b ier=%h",
                 iir, irq, ier_q, model_iir(), model_id() != 1, m_en);
      end
    end
  end

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic pulse_ier(logic [7:0] d);
    tick(); ier_wr = 1; ier_wdata = d; tick(); ier_wr = 0; #1;
  endtask

  task automatic pulse_rd();
    tick(); iir_rd = 1; tick(); iir_rd = 0; #1;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1; #1;
    chk("R10 reset iir", iir, 8'h01);
    chk("R10 reset irq", {7'b0, irq}, 8'h00);
    chk("R10 reset ier", ier_q, 8'h00);

    thr_empty = 1;
    pulse_ier(8'hFF);
    chk("R1 ier upper bits dropped", ier_q, 8'h0F);
    chk("R9 R5 pend set by enable write", iir, 8'h02);
    chk("R7 irq high", {7'b0, irq}, 8'h01);

    pulse_rd();
    chk("R8 read of txe id clears", iir, 8'h01);
    chk("R7 irq low", {7'b0, irq}, 8'h00);

    tick(); msr_delta = 4'b0100; #1;
    chk("R6 modem id", iir, 8'h00);
    chk("R7 irq for modem", {7'b0, irq}, 8'h01);

    tick(); data_ready = 1; #1;
    chk("R4 rx data no fifo", iir, 8'h04);

    tick(); fifo_en = 1; rx_count = 3; rx_trigger = 4; #1;
    chk("R4 below trigger", iir, 8'hC0);
    tick(); rx_count = 4; #1;
    chk("R4 at trigger", iir, 8'hC4);

    tick(); rx_timeout = 1; #1;
    chk("R3 timeout over rx", iir, 8'hCC);
    thr_empty = 0;
    pulse_ier(8'h0E);
    chk("R3 timeout masked by bit0", iir, 8'hC0);

    tick(); line_err = 4'b1000; #1;
    chk("R2 line status top", iir, 8'hC6);
    pulse_ier(8'h0F);
    chk("R2 line over timeout", iir, 8'hC6);

    tick(); tx_empty_evt = 1; thr_wr = 1; tick(); tx_empty_evt = 0; thr_wr = 0; #1;
    pulse_rd();
    tick(); line_err = 0; rx_timeout = 0; data_ready = 0; msr_delta = 0; #1;
    chk("R8 thr write beats set", iir, 8'hC1);

    tick(); tx_empty_evt = 1; line_err = 4'b0001; tick(); tx_empty_evt = 0; #1;
    chk("R9 event sets pend, line wins", iir, 8'hC6);
    pulse_rd();
    tick(); line_err = 0; #1;
    chk("R8 read of other id keeps pend", iir, 8'hC2);
    tick(); thr_wr = 1; tick(); thr_wr = 0; #1;
    chk("R8 thr write clears", iir, 8'hC1);

    tick(); fifo_en = 0; #1;
    chk("R6 no source", iir, 8'h01);
    chk("R7 irq low idle", {7'b0, irq}, 8'h00);

    repeat (3) tick();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule